// File: doc/BRIEF.md
# Integer to Single-Precision Float Converter

This block turns a 32-bit integer word into the 32-bit pattern of an IEEE-754 single-precision value. A select input tells it whether the word is an unsigned count or a two's complement number. A valid strobe qualifies each word. One clock later the packed float appears on a registered output, with its own valid and an inexact flag.

The datapath runs as one combinational chain in front of the output register. It first takes the magnitude and notes the sign. It then finds the most significant one. Next it moves that one to the top of a normalisation window and rounds the window to 24 significant bits, ties going to even. Last, it forms the biased exponent and packs sign, exponent and fraction.

A host feeds one word per cycle. It can also leave gaps: while the strobe is low the outputs keep their last value.

Top module: `i2f_conv`

## Requirements
- R1: While reset is high, and on the first cycle after it, out_valid, out_result and out_inexact are all zero.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is low, out_result and out_inexact keep their previous values.
- R3: An input of zero produces out_result 0x00000000 with out_inexact 0, in both modes.
- R4: With in_signed=1 the input is two's complement. A set bit 31 gives result bit 31 = 1, and the magnitude converted is the two's complement negation. With in_signed=0 the input is unsigned and result bit 31 is always 0.
- R5: The exponent field (result bits 30:23) equals 127 plus the bit index of the magnitude's highest set bit, plus one more when rounding carries out (R8).
- R6: The fraction field (result bits 22:0) holds the 23 bits that follow the leading one, and the leading one is dropped. Magnitudes below 2^24 convert exactly.
- R7: When bits fall below the 24-bit significand, the result rounds to nearest. A discarded part of exactly one half rounds to the even significand.
- R8: When rounding overflows the significand, the fraction becomes zero and the exponent goes up by one. For example, unsigned 0xFFFFFFFF gives 0x4F800000.
- R9: out_inexact is 1 exactly when any discarded magnitude bit is nonzero.
- R10: In signed mode, 0x80000000 converts to 0xCF000000 with out_inexact 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_signed | input | 1 | 1: two's complement input, 0: unsigned input |
| in_data | input | INT_W (32) | Integer to convert |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Packed single-precision pattern |
| out_inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The bound checker watches these on every cycle:
- valid timing and holding of the output;
- the zero case and the sign bit in both modes;
- the range of the exponent field;
- exactness of unsigned inputs below 2^24;
- the most negative signed input.

Correct rounding can only be shown by the bench's scenarios, which compare against an arithmetic model that uses remainder and half. These scenarios cover ties to even, the carry-out into the exponent and the exact inexact flag. They sweep every power of two and its neighbours, dense low and negative ranges, constructed tie patterns and a long pseudo-random run in both modes.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXP_W  = 8;
  localparam int BIAS   = 127;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [FRAC_W-1:0] frac;
  } fp32_t;
endpackage

// File: rtl/i2f_abs.sv
// Sign extraction and magnitude formation.
module i2f_abs #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic         is_signed,
  output logic         neg,
  output logic [W-1:0] mag
);
  assign neg = is_signed & val[W-1];
  // The most negative value maps onto itself, which is the correct unsigned magnitude.
  assign mag = neg ? (~val + W'(1)) : val;
endmodule

// File: rtl/i2f_lead_one.sv
// Index of the most significant set bit; zero when the vector is empty.
module i2f_lead_one #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = IDX_W'(i);
    end
  end
endmodule

// File: rtl/i2f_round_pack.sv
// Normalise, round to nearest-even at the significand boundary, bias and pack.
module i2f_round_pack
  import i2f_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     mag,
  input  logic [IDX_W-1:0] pos,
  input  logic             neg,
  output fp32_t            word,
  output logic             inexact
);
  localparam int EXT_W = (W >= SIG_W + 2) ? W : SIG_W + 2;

  logic [W-1:0]     norm;
  logic [EXT_W-1:0] ext;
  logic [SIG_W-1:0] keep;
  logic             guard, sticky, round_up, carry, nonzero;
  logic [SIG_W:0]   sum;

  // Leading one moved to the top bit of the window.
  assign norm = mag << (IDX_W'(W - 1) - pos);

  generate
    if (EXT_W == W) begin : g_wide
      assign ext = norm;
    end else begin : g_narrow
      assign ext = {norm, {(EXT_W - W){1'b0}}};
    end
  endgenerate

  assign keep     = ext[EXT_W-1 -: SIG_W];
  assign guard    = ext[EXT_W-SIG_W-1];
  assign sticky   = |ext[EXT_W-SIG_W-2:0];
  assign round_up = guard & (sticky | keep[0]);
  assign sum      = {1'b0, keep} + (SIG_W + 1)'(round_up);
  assign carry    = sum[SIG_W];
  assign nonzero  = sum[SIG_W] | sum[SIG_W-1];

  always_comb begin
    word = '0;
    if (nonzero) begin
      word.sign = neg;
      word.exp  = EXP_W'(BIAS) + EXP_W'(pos) + EXP_W'(carry);
      word.frac = sum[FRAC_W-1:0];
    end
  end

  assign inexact = guard | sticky;
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import i2f_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_signed,
  input  logic [INT_W-1:0] in_data,
  output logic             out_valid,
  output logic [31:0]      out_result,
  output logic             out_inexact
);
  localparam int IDX_W = $clog2(INT_W);

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [IDX_W-1:0] pos;
  fp32_t            word;
  logic             inexact;

  i2f_abs #(.W(INT_W)) u_abs (
    .val(in_data), .is_signed(in_signed), .neg(neg), .mag(mag)
  );

  i2f_lead_one #(.W(INT_W), .IDX_W(IDX_W)) u_lead (
    .vec(mag), .pos(pos)
  );

  i2f_round_pack #(.W(INT_W), .IDX_W(IDX_W)) u_pack (
    .mag(mag), .pos(pos), .neg(neg), .word(word), .inexact(inexact)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= word;
        out_inexact <= inexact;
      end
    end
  end
endmodule

// File: rtl/i2f_conv_chk.sv
module i2f_conv_chk #(
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_signed,
  input logic [INT_W-1:0] in_data,
  input logic             out_valid,
  input logic [31:0]      out_result,
  input logic             out_inexact
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_inexact)));
  a_r3_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_result == 32'h0 && !out_inexact));
  a_r4_unsigned_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed) |=> !out_result[31]);
  a_r4_signed_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed) |=> (out_result[31] == $past(in_data[INT_W-1])));
  a_r5_exp_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_result[30:0] != 31'h0) |->
      (out_result[30:23] >= 8'd127 && out_result[30:23] <= 8'(127 + INT_W)));
  a_r6_small_exact: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed && (in_data >> 24) == '0) |=> !out_inexact);
  a_r10_min_neg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_signed && in_data == {1'b1, {(INT_W-1){1'b0}}}) |=>
      (out_result == 32'hCF00_0000 && !out_inexact));
endmodule

bind i2f_conv i2f_conv_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
  .in_data(in_data), .out_valid(out_valid), .out_result(out_result),
  .out_inexact(out_inexact)
);

// File: tb/i2f_conv_test.sv
`timescale 1ns/1ps
module i2f_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_signed = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2f_conv #(.INT_W(32)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_signed(in_signed),
    .in_data(in_data), .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact)
  );

  // Arithmetic model: quotient, remainder and half comparisons.
  function automatic void model(input logic [31:0] d, input logic s,
                                output logic [31:0] r, output logic inx,
                                output logic cy);
    logic [63:0] m, q, rem, half;
    logic        sg;
    int          msb, sh, e;
    sg = s && d[31];
    m  = sg ? (64'h1_0000_0000 - {32'h0, d}) : {32'h0, d};
    r = '0; inx = 1'b0; cy = 1'b0;
    if (m == 0) return;
    msb = 0;
    for (int i = 0; i < 64; i++) if (m[i]) msb = i;
    e = 127 + msb;
    if (msb <= 23) begin
      q = m << (23 - msb);
    end else begin
      sh   = msb - 23;
      q    = m >> sh;
      rem  = m - (q << sh);
      half = 64'h1 << (sh - 1);
      inx  = (rem != 0);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == 64'h100_0000) begin q = 64'h80_0000; e = e + 1; cy = 1'b1; end
    end
    r = {sg, 8'(e), q[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic s);
    logic [31:0] er;
    logic        ei, ec;
    string       tag;
    model(d, s, er, ei, ec);
    in_valid = 1'b1; in_signed = s; in_data = d;
    @(negedge clk);
    if (d == 0)                        tag = "R3";
    else if (s && d == 32'h8000_0000)  tag = "R10";
    else if (ec)                       tag = "R8";
    else if (ei)                       tag = "R7";
    else if (s && d[31])               tag = "R4";
    else                               tag = "R6/R5";
    check({tag, " valid"}, {31'h0, out_valid}, 32'h1);  // R2
    check(tag, out_result, er);
    check({"R9 via ", tag}, {31'h0, out_inexact}, {31'h0, ei});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, held;
    logic        hi;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'h0, out_valid}, 32'h0);
    check("R1 result", out_result, 32'h0);
    check("R1 inexact", {31'h0, out_inexact}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {30'h0, out_valid, out_inexact}, 32'h0);

    // R3 zero in both modes, R10 most negative, R8 all-ones
    apply(32'h0, 1'b0);
    apply(32'h0, 1'b1);
    apply(32'h8000_0000, 1'b1);
    check("R10 literal", out_result, 32'hCF00_0000);
    apply(32'hFFFF_FFFF, 1'b0);
    check("R8 literal", out_result, 32'h4F80_0000);
    apply(32'hFFFF_FFFF, 1'b1);
    check("R4 minus one", out_result, 32'hBF80_0000);

    // R7 tie patterns: 2^24+1 rounds down to even, 2^24+3 rounds up
    apply(32'h0100_0001, 1'b0);
    check("R7 tie down", out_result, 32'h4B80_0000);
    apply(32'h0100_0003, 1'b0);
    check("R7 tie up", out_result, 32'h4B80_0002);

    // Powers of two and neighbours, R5 and R6
    for (int k = 0; k < 32; k++) begin
      for (int sm = 0; sm < 2; sm++) begin
        apply(32'h1 << k, sm[0]);
        apply((32'h1 << k) - 1, sm[0]);
        apply((32'h1 << k) + 1, sm[0]);
        apply(~(32'h1 << k), sm[0]);
      end
    end

    // Dense low and negative ranges
    for (int v = 0; v < 4096; v++) begin
      apply(32'(v), 1'b0);
      apply(32'(-v), 1'b1);
    end

    // Tie sweep around each rounding position
    for (int k = 25; k < 32; k++) begin
      for (int t = 0; t < 8; t++) begin
        x = (32'h1 << k) | (32'(t) << (k - 23)) | (32'h1 << (k - 24));
        apply(x, 1'b0);
        apply(x, 1'b1);
      end
    end

    // Pseudo-random run
    x = 32'h1234_5678;
    for (int n = 0; n < 20000; n++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      apply(x, x[7]);
    end

    // R2: idle cycle holds outputs and drops valid
    apply(32'h0000_0003, 1'b0);
    held = out_result; hi = out_inexact;
    in_valid = 1'b0; in_data = 32'hDEAD_BEEF; in_signed = 1'b1;
    @(negedge clk);
    check("R2 idle valid", {31'h0, out_valid}, 32'h0);
    check("R2 hold result", out_result, held);
    check("R2 hold inexact", {31'h0, out_inexact}, {31'h0, hi});
    check("R2 held value", held, 32'h4040_0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule